// File: doc/BRIEF.md
# Residual Time Stamp Generator for Constant-Bit-Rate Cells

This block sits on the transmit side of a constant-bit-rate cell adaptation layer. A counter advances on every pulse of a network-clock enable. Both ends of the connection share this network clock. In parallel, a period timer counts pulses of a service-bit enable. Each time the timer completes one measurement period, the four low bits of the network-clock counter are captured. These four bits form the residual time stamp. The measurement period is 3008 service bits, which is eight cells of 47 octets.

The header builder presents each outgoing cell's 3-bit sequence count together with a request strobe. The block answers in the same cycle with the convergence-sublayer indication (CSI) bit for that cell. A captured residual first waits in a pending register. It becomes the applied residual only at a cell whose count is 0. Its four bits are then sent most significant bit first, in the cells whose counts are 1, 3, 5 and 7. Cells with even counts carry a 0 in that bit.

Both enables and the cell strobe belong to one system clock domain.

Top module: `resid_stamp_gen`

## Requirements
- R1: The network-clock counter is CNT_W bits wide. It advances by one in every cycle where `net_en` is high and wraps from all ones to zero without stopping.
- R2: The period timer counts cycles where `svc_en` is high. The PERIOD-th such cycle ends a period and starts the next count from zero. At that point the pending residual takes bits [3:0] of the network counter as held at the start of that cycle; a `net_en` pulse in the same cycle is not included.
- R3: With `cell_req` high and `cell_sn` odd, `csi` carries one bit of the applied residual. Count 1 carries bit 3, count 3 bit 2, count 5 bit 1 and count 7 bit 0. The value is valid in the same cycle.
- R4: With `cell_req` high and `cell_sn` even (0, 2, 4, 6), `csi` is 0.
- R5: The applied residual is loaded from the pending residual only at a clock edge where `cell_req` is high and `cell_sn` is 0. A capture in that same cycle is not used; it waits for the next count-0 cell. A capture made part-way through an eight-cell group leaves the group's remaining CSI bits unchanged.
- R6: While `cell_req` is low, `csi` is 0.
- R7: A synchronous active-low reset clears the network counter, the period timer, the pending residual and the applied residual. After reset, `csi` is 0 for every count until a capture has been applied. The first capture then needs PERIOD service enables.
- R8: Without a new capture, every count-0 cell re-applies the same pending residual. Later groups therefore repeat the same four bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| svc_en | input | 1 | One pulse per service data bit |
| net_en | input | 1 | One pulse per derived network-clock tick |
| cell_req | input | 1 | A cell header is being formed this cycle |
| cell_sn | input | 3 | Sequence count of that cell |
| csi | output | 1 | CSI bit for the presented cell |

## Verification
The bench builds the block with a 12-enable period and a 5-bit network counter. Captures therefore come every few dozen cycles, and the counter wraps many times in one run. Varied enable densities drive every residual value through all four odd slots.

With period 12, a capture can be placed exactly on a count-0 cell, so the deferral rule is checked directly. The same setting gives captures part-way through a group and long runs without any capture. A reset in the middle of a run confirms that every register is cleared again.

// File: rtl/rsg_pkg.sv
// Shared helpers for the residual time stamp generator.
// Assumes: nothing beyond elaboration-time integer arithmetic.
package rsg_pkg;

    // Width of a counter that must hold the values 0 .. n-1 (at least 1 bit).
    function automatic int cnt_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Sequence count of the cell that carries slot k (k = 0 is the MSB).
    function automatic int slot_count(input int k);
        return 2 * k + 1;
    endfunction

endpackage

// File: rtl/rsg_net_counter.sv
// Free-running counter of network-clock enables.
// Assumes: net_en is a single-cycle pulse qualifier in the clk domain.
module rsg_net_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             net_en,
    output logic [CNT_W-1:0] cnt
);

    // Advance on each network tick; wraps naturally at 2**CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (net_en)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/rsg_period_timer.sv
// Counts service-bit enables and flags the last enable of each period.
// Assumes: PERIOD >= 2.
module rsg_period_timer #(
    parameter int PERIOD = 3008,
    parameter int PER_W  = rsg_pkg::cnt_bits(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc_en,
    output logic             period_end,
    output logic [PER_W-1:0] per_cnt
);

    localparam logic [PER_W-1:0] LAST = PER_W'(PERIOD - 1);

    // Period completes on the enable that finds the counter at its last value.
    always_comb period_end = svc_en && (per_cnt == LAST);

    // Step the count on each service enable, restarting after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            per_cnt <= '0;
        else if (period_end)
            per_cnt <= '0;
        else if (svc_en)
            per_cnt <= per_cnt + 1'b1;
    end

endmodule

// File: rtl/rsg_csi_mux.sv
// Holds the pending and applied residuals and selects the CSI bit per cell.
// Assumes: RES_W == 2**(SEQ_W-1), so every odd count owns exactly one bit.
module rsg_csi_mux #(
    parameter int SEQ_W = 3,
    parameter int RES_W = 2 ** (SEQ_W - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [RES_W-1:0] cap_val,
    input  logic             cell_req,
    input  logic [SEQ_W-1:0] cell_sn,
    output logic [RES_W-1:0] pend_res,
    output logic [RES_W-1:0] act_res,
    output logic             csi
);

    logic             group_start;
    logic [RES_W-1:0] slot_hit;
    logic [RES_W-1:0] slot_bit;

    // A new eight-cell group begins at a count-0 cell.
    always_comb group_start = cell_req && (cell_sn == '0);

    // Latch each finished measurement as the pending residual.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_res <= '0;
        else if (capture)
            pend_res <= cap_val;
    end

    // Apply the pending residual only at a group boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_res <= '0;
        else if (group_start)
            act_res <= pend_res;
    end

    // One decoder per odd slot; slot k carries residual bit RES_W-1-k.
    for (genvar k = 0; k < RES_W; k++) begin : g_slot
        always_comb begin
            slot_hit[k] = cell_req && (cell_sn == SEQ_W'(rsg_pkg::slot_count(k)));
            slot_bit[k] = act_res[RES_W-1-k];
        end
    end

    // At most one slot matches; even counts and idle cycles give 0.
    always_comb csi = |(slot_hit & slot_bit);

endmodule

// File: rtl/resid_stamp_gen.sv
// Residual time stamp generator: measures network ticks over a fixed number
// of service bits and spreads the low residual bits over the odd cells.
// Assumes: all enables and the cell strobe are synchronous to clk; CNT_W >= RES_W.
module resid_stamp_gen #(
    parameter int PERIOD = 3008,
    parameter int CNT_W  = 16,
    parameter int SEQ_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc_en,
    input  logic             net_en,
    input  logic             cell_req,
    input  logic [SEQ_W-1:0] cell_sn,
    output logic             csi
);

    localparam int RES_W = 2 ** (SEQ_W - 1);
    localparam int PER_W = rsg_pkg::cnt_bits(PERIOD);

    logic [CNT_W-1:0] net_cnt;
    logic             period_end;
    logic [PER_W-1:0] per_cnt;
    logic [RES_W-1:0] pend_res;
    logic [RES_W-1:0] act_res;

    rsg_net_counter #(.CNT_W(CNT_W)) u_net (
        .clk    (clk),
        .rst_n  (rst_n),
        .net_en (net_en),
        .cnt    (net_cnt)
    );

    rsg_period_timer #(.PERIOD(PERIOD), .PER_W(PER_W)) u_per (
        .clk        (clk),
        .rst_n      (rst_n),
        .svc_en     (svc_en),
        .period_end (period_end),
        .per_cnt    (per_cnt)
    );

    rsg_csi_mux #(.SEQ_W(SEQ_W), .RES_W(RES_W)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (period_end),
        .cap_val  (net_cnt[RES_W-1:0]),
        .cell_req (cell_req),
        .cell_sn  (cell_sn),
        .pend_res (pend_res),
        .act_res  (act_res),
        .csi      (csi)
    );

endmodule

// File: rtl/resid_stamp_gen_chk.sv
// Temporal checks for resid_stamp_gen, attached by bind.
// Assumes: connected to the top module's internal nets of the same names.
module resid_stamp_gen_chk #(
    parameter int CNT_W = 16,
    parameter int SEQ_W = 3,
    parameter int RES_W = 4,
    parameter int PER_W = 12,
    parameter int PERIOD = 3008
) (
    input logic             clk,
    input logic             rst_n,
    input logic             svc_en,
    input logic             net_en,
    input logic             cell_req,
    input logic [SEQ_W-1:0] cell_sn,
    input logic             csi,
    input logic [CNT_W-1:0] net_cnt,
    input logic             period_end,
    input logic [PER_W-1:0] per_cnt,
    input logic [RES_W-1:0] pend_res,
    input logic [RES_W-1:0] act_res
);

    // R1
    net_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        net_en |=> net_cnt == $past(net_cnt) + 1'b1);

    // R1
    net_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !net_en |=> $stable(net_cnt));

    // R2
    per_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_cnt < PER_W'(PERIOD));

    // R2
    capture_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(pend_res));

    // R2
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> pend_res == $past(net_cnt[RES_W-1:0]));

    // R5
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cell_req && cell_sn == '0) |=> $stable(act_res));

    // R4
    even_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_req && !cell_sn[0]) |-> !csi);

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_req |-> !csi);

endmodule

bind resid_stamp_gen resid_stamp_gen_chk #(
    .CNT_W(CNT_W), .SEQ_W(SEQ_W), .RES_W(RES_W), .PER_W(PER_W), .PERIOD(PERIOD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .svc_en(svc_en), .net_en(net_en),
    .cell_req(cell_req), .cell_sn(cell_sn), .csi(csi), .net_cnt(net_cnt),
    .period_end(period_end), .per_cnt(per_cnt), .pend_res(pend_res),
    .act_res(act_res)
);

// File: tb/sim_resid_stamp_gen.sv
// Bench: small period and counter, expected CSI computed from the requirements.
module sim_resid_stamp_gen;

    localparam int P     = 12;
    localparam int CW    = 5;
    localparam int SW    = 3;
    localparam int NMOD  = 2 ** CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          svc_en = 1'b0;
    logic          net_en = 1'b0;
    logic          cell_req = 1'b0;
    logic [SW-1:0] cell_sn = '0;
    logic          csi;

    int errors = 0;
    int checks = 0;
    int m_net = 0;
    int m_per = 0;
    int m_pend = 0;
    int m_act = 0;
    int seq = 0;
    int lfsr = 32'h1d3;
    bit finished = 0;

    always #2.5 clk = ~clk;

    resid_stamp_gen #(.PERIOD(P), .CNT_W(CW), .SEQ_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .svc_en(svc_en), .net_en(net_en),
        .cell_req(cell_req), .cell_sn(cell_sn), .csi(csi)
    );

    task automatic check(input string tag, input int exp);
        checks++;
        if (int'(csi) != exp) begin
            errors++;
            $display("FAIL %s: sn=%0d req=%0b csi=%0d expected %0d",
                     tag, cell_sn, cell_req, csi, exp);
        end
    endtask

    // One cycle: drive, check the combinational answer, advance the model.
    task automatic step(input bit s, input bit n, input bit r, input int sn, input string tag);
        int exp;
        @(negedge clk);
        svc_en = s; net_en = n; cell_req = r; cell_sn = SW'(sn);
        #1;
        if (!r)               check("R6", 0);
        else if (sn % 2 == 0) check("R4", 0);
        else begin
            exp = (m_act >> (3 - sn / 2)) & 1;
            check(tag, exp);
        end
        // Model update from R1, R2, R5.
        if (r && sn == 0) m_act = m_pend;
        if (s) begin
            if (m_per == P - 1) begin m_pend = m_net % 16; m_per = 0; end
            else m_per++;
        end
        if (n) m_net = (m_net + 1) % NMOD;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; svc_en = 0; net_en = 0; cell_req = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_net = 0; m_per = 0; m_pend = 0; m_act = 0; seq = 0;
    endtask

    function automatic bit rnd(input int bitpos);
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
        return lfsr[bitpos];
    endfunction

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: expired, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R7: all counts give 0 right after reset.
        for (int sn = 0; sn < 8; sn++) step(0, 0, 1, sn, "R7");
        // R7: first capture needs a full period; cells before it remain 0.
        for (int i = 0; i < P - 1; i++) step(1, 1, 1, (i % 8) | 1, "R7");

        // R3/R2: cells every cycle, densities of both enables swept.
        for (int sd = 1; sd <= 3; sd++)
            for (int nd = 1; nd <= 4; nd++)
                for (int c = 0; c < 200; c++) begin
                    step((c % sd) == 0, (c % nd) != 0 || nd == 1, 1, seq, "R2");
                    seq = (seq + 1) % 8;
                end

        // R1: net ticks every cycle wrap the 5-bit counter many times.
        for (int c = 0; c < 1500; c++) begin
            step(rnd(0), 1, 1, seq, "R1");
            seq = (seq + 1) % 8;
        end

        // R3/R6: sparse random cells with random enables, all residuals.
        for (int c = 0; c < 3000; c++) begin
            bit r;
            r = rnd(3);
            step(rnd(1), rnd(2), r, seq, "R3");
            if (r) seq = (seq + 1) % 8;
        end

        // R7: mid-run reset clears everything again.
        do_reset();
        for (int sn = 0; sn < 8; sn++) step(0, 1, 1, sn, "R7");

        // R5: capture lands exactly on a count-0 cell and is deferred a group.
        do_reset();
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R5");
        seq = (8 - (P - 1) % 8) % 8;
        for (int c = 0; c < 40; c++) begin
            step(c < P, 1, 1, seq, "R5");
            seq = (seq + 1) % 8;
        end

        // R8: no service enables, so groups repeat the held residual.
        for (int c = 0; c < 64; c++) begin
            step(0, 1, 1, seq, "R8");
            seq = (seq + 1) % 8;
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule